// File: doc/BRIEF.md
# Dual-Operation Accumulating Register

This block is a register of parameterised width, one bit per cell, that can fold an input word into its stored value in one of two ways. On each rising clock edge it either keeps its contents, replaces them with their bitwise OR against the input word, or replaces them with their bitwise XOR against the input word. Two separate select inputs choose the operation, and at most one of them may be high in a cycle.

Each bit is an independent cell. A cell's next value depends only on its own stored bit, its own input bit and the two shared selects. The cells update every cycle through a single next-state expression rather than through a flip-flop enable: an idle cycle gives the same value back. If both selects are high, the register keeps its value and reports the condition on an error output for the following cycle. A synchronous active-high reset clears the register and the error output.

Top module: `dual_op_reg`

## Requirements
- R1: A cycle with `rst` high clears `acc` to all zeros and `ctl_err` to 0 at that clock edge.
- R2: With `or_en`=0 and `xor_en`=0, `acc` keeps its value across the clock edge.
- R3: With `or_en`=1 and `xor_en`=0, `acc` becomes `acc | din` at the clock edge.
- R4: With `xor_en`=1 and `or_en`=0, `acc` becomes `acc ^ din` at the clock edge.
- R5: With both `or_en` and `xor_en` at 1, `acc` keeps its value across the clock edge.
- R6: `ctl_err` is 1 for exactly the cycle that follows a clock edge at which both selects were 1, and 0 after any edge at which they were not.
- R7: Bit i of the next `acc` depends only on bit i of `acc`, bit i of `din` and the two selects, for every bit position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| or_en | input | 1 | Select: merge `din` into `acc` with OR |
| xor_en | input | 1 | Select: merge `din` into `acc` with XOR |
| din | input | WIDTH | Input word |
| acc | output | WIDTH | Stored register value |
| ctl_err | output | 1 | High for one cycle after both selects were high |

## Verification
Every result is due one clock edge after its stimulus: `acc` and `ctl_err` both come straight from flip-flops that capture the selects and `din` at that edge. The bench drives inputs on the falling edge. It lets exactly one rising edge pass and then compares on the next falling edge. The expected value comes from the OR or XOR of the previous expected state with the driven word. A four-bit instance is swept over every start value, every input word and every select combination. An idle cycle after each illegal one confirms that the error pulse has dropped.

// File: rtl/dual_op_reg_pkg.sv
package dual_op_reg_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_XOR  = 2'b01,
    OP_OR   = 2'b10,
    OP_BAD  = 2'b11
  } op_t;

  function automatic op_t decode_op(input logic or_sel, input logic xor_sel);
    return op_t'({or_sel, xor_sel});
  endfunction
endpackage

// File: rtl/dual_op_ctl.sv
module dual_op_ctl
  import dual_op_reg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic or_en,
  input  logic xor_en,
  output logic or_gate,
  output logic xor_gate,
  output logic err_q
);
  op_t op;

  always_comb begin
    op       = decode_op(or_en, xor_en);
    or_gate  = (op == OP_OR);
    xor_gate = (op == OP_XOR);
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= (op == OP_BAD);
  end

  AST_ERR_AFTER_BAD: assert property (@(posedge clk) disable iff (rst)
    (or_en && xor_en) |=> err_q);  // R6
  AST_ERR_CLEAR_OK: assert property (@(posedge clk) disable iff (rst)
    !(or_en && xor_en) |=> !err_q);  // R6
endmodule

// File: rtl/dual_op_cell.sv
module dual_op_cell (
  input  logic clk,
  input  logic rst,
  input  logic or_gate,
  input  logic xor_gate,
  input  logic b,
  output logic q
);
  logic nxt;

  always_comb nxt = (or_gate & b) | (q ^ (xor_gate & b));

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end

  AST_CELL_OR_SETS: assert property (@(posedge clk) disable iff (rst)
    (or_gate && b) |=> q);  // R3
  AST_CELL_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!or_gate && !xor_gate) |=> $stable(q));  // R7
endmodule

// File: rtl/dual_op_reg.sv
module dual_op_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             or_en,
  input  logic             xor_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] acc,
  output logic             ctl_err
);
  localparam int LAST = WIDTH - 1;

  logic or_gate;
  logic xor_gate;

  dual_op_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .or_en    (or_en),
    .xor_en   (xor_en),
    .or_gate  (or_gate),
    .xor_gate (xor_gate),
    .err_q    (ctl_err)
  );

  for (genvar i = 0; i <= LAST; i++) begin : g_cell
    dual_op_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .or_gate  (or_gate),
      .xor_gate (xor_gate),
      .b        (din[i]),
      .q        (acc[i])
    );
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (acc == '0 && !ctl_err));  // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!or_en && !xor_en) |=> $stable(acc));  // R2
  AST_OR_MERGE: assert property (@(posedge clk) disable iff (rst)
    (or_en && !xor_en) |=> acc == ($past(acc) | $past(din)));  // R3
  AST_XOR_MERGE: assert property (@(posedge clk) disable iff (rst)
    (xor_en && !or_en) |=> acc == ($past(acc) ^ $past(din)));  // R4
  AST_BAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (or_en && xor_en) |=> $stable(acc));  // R5
endmodule

// File: tb/dual_op_reg_tb.sv
module dual_op_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst;
  logic         or_en;
  logic         xor_en;
  logic [W-1:0] din;
  logic [W-1:0] acc;
  logic         ctl_err;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_op_reg #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .or_en(or_en), .xor_en(xor_en),
    .din(din), .acc(acc), .ctl_err(ctl_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic o, input logic x, input logic [W-1:0] d);
    or_en = o; xor_en = x; din = d;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; or_en = 1'b1; xor_en = 1'b1; din = '1;
    @(negedge clk); @(negedge clk);
    chk("R1 acc", int'(acc), 0);
    chk("R1 err", int'(ctl_err), 0);
    rst = 1'b0;
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < N; d++) begin
        for (int op = 0; op < 4; op++) begin
          logic [W-1:0] exp;
          logic o, x;
          o = op[1]; x = op[0];
          // preload: reset then xor-load start value s
          rst = 1'b1; cyc(0, 0, '0);
          rst = 1'b0;
          cyc(0, 1, W'(s));
          chk("R4 preload", int'(acc), s);
          cyc(o, x, W'(d));
          if (o && !x)      exp = W'(s) | W'(d);
          else if (x && !o) exp = W'(s) ^ W'(d);
          else              exp = W'(s);
          if (o && x) begin
            chk("R5 bad hold", int'(acc), int'(exp));
            chk("R6 err set", int'(ctl_err), 1);
            cyc(0, 0, ~W'(d));
            chk("R6 err drop", int'(ctl_err), 0);
            chk("R2 idle hold", int'(acc), int'(exp));
          end else if (o) begin
            chk("R3 or merge", int'(acc), int'(exp));
            chk("R6 err low", int'(ctl_err), 0);
          end else if (x) begin
            chk("R4 xor merge", int'(acc), int'(exp));
            chk("R6 err low", int'(ctl_err), 0);
          end else begin
            chk("R2 idle hold", int'(acc), int'(exp));
          end
        end
      end
    end
    // R7: single-bit inputs only affect their own bit
    for (int b = 0; b < W; b++) begin
      rst = 1'b1; cyc(0, 0, '0);
      rst = 1'b0;
      cyc(0, 1, W'(5));
      cyc(0, 1, W'(1) << b);
      chk("R7 own bit xor", int'(acc), int'(W'(5) ^ (W'(1) << b)));
      cyc(1, 0, W'(1) << b);
      chk("R7 own bit or", int'(acc), int'((W'(5) ^ (W'(1) << b)) | (W'(1) << b)));
    end
    // R1 mid-run reset with selects active
    rst = 1'b1; cyc(1, 0, '1);
    chk("R1 mid reset", int'(acc), 0);
    rst = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule